// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

The block gathers up to 32 interrupt sources and presents them to a processor through two register banks of identical layout. The banks read the same inputs. One bank drives the normal interrupt line and the other drives the fast interrupt line. Each bank has its own enable mask and its own trigger configuration, so a source can be routed to either line, to both lines, or to neither.

Every source passes through a two-flop synchronizer. Each bank then treats the source as level-sensitive or edge-triggered, and as active-high or active-low, according to that bank's per-source select bits. An edge event is held in a sticky latch until software acknowledges it by writing a one to that bit of the acknowledge register. Each output line is a registered OR of its bank's enabled, pending sources.

Software reaches the registers through a single-cycle strobe bus. A write takes effect at the clock edge where the strobe is sampled. Read data is registered at the edge where the read strobe is sampled, and it holds its value until the next read.

Top module: `irq_dual_ctrl`

## Requirements
- R1: A synchronous reset clears the enable masks, the trigger-mode bits, the polarity bits and the edge latches of both banks. It also drives both interrupt lines and the read data to 0.
- R2: Each bank has six word registers at index offsets 0 to 5: pending view 0x00, enable mask 0x04, acknowledge 0x08, trigger mode 0x0C, polarity 0x10 and enabled-pending view 0x14. The normal bank is at base 0x00 and the fast bank at base 0x20. Reads of the acknowledge register, of misaligned addresses, of index 6 or 7, or of any address at 0x40 or above return 0.
- R3: Mask bit i = 1 enables source i in that bank. The enabled-pending view equals the pending view AND the mask.
- R4: Polarity bit i = 1 selects active-high (level mode) or rising edge (edge mode) for source i. Polarity bit i = 0 selects active-low or falling edge. Changing the polarity of a steady input never creates an edge event.
- R5: Trigger-mode bit i = 0 makes source i level-sensitive. Its pending bit then reads as the synchronized input corrected for polarity. An input sampled at edge k is seen by the logic after edge k+1.
- R6: Trigger-mode bit i = 1 makes source i edge-triggered. A detected edge sets the latch at edge k+2, and the pending bit reads as that latch until it is acknowledged.
- R7: Writing the acknowledge register clears the latch of each edge-mode source whose written bit is 1. Bits written as 0 have no effect, and level-mode sources are unaffected.
- R8: If an edge is detected in the same cycle that its bit is acknowledged, the latch stays set.
- R9: The two banks share the synchronized inputs. A write to one bank never changes the other bank's registers or output.
- R10: Each interrupt line is a register loaded every cycle with the OR of its bank's enabled-pending bits. A write of 0 to a mask forces that bank's line low two edges after the write is sampled.
- R11: Writes to the pending view, the enabled-pending view or unmapped addresses change no state. The read data changes only at edges where the read strobe is sampled.
- R12: The edge latch of a source in level mode is held at 0, so switching a source from edge to level mode and back discards a pending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Asynchronous interrupt source inputs |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_n_o | output | 1 | Normal interrupt line |
| irq_f_o | output | 1 | Fast interrupt line |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit data bus and an 8-bit address. With an 8-bit address the bench can reach the unmapped space above 0x3F as well as both bank bases. With 32 sources every bit of a bus word maps to a source, so full-word writes exercise all sources of both banks at once. Directed sequences place an edge on the same cycle as its acknowledge, flip polarity and trigger mode under steady inputs, and drive one input through both banks with different masks. On every cycle the bench also compares both lines and the read data against its behavioural model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  // register index inside a bank, taken from address bits [4:2]
  typedef enum logic [2:0] {
    REG_PEND  = 3'd0,
    REG_MASK  = 3'd1,
    REG_ACK   = 3'd2,
    REG_MODE  = 3'd3,
    REG_POL   = 3'd4,
    REG_EPEND = 3'd5
  } reg_sel_e;

  localparam int NBANKS      = 2;
  localparam int BANK_BIT    = 5;   // 0x20 selects the fast bank
  localparam int SPACE_BITS  = 6;   // 0x00..0x3F is the decoded window
  localparam int NREGS       = 6;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  localparam int NFLOPS = STAGES + 1;

  logic [W-1:0] chain [NFLOPS];

  genvar g;
  generate
    for (g = 0; g < NFLOPS; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
  assign prev_o = chain[STAGES];

endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] sync_i,
  input  logic [NSRC-1:0] prev_i,
  input  logic            wr_i,
  input  reg_sel_e        wsel_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] epend_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] mode_o,
  output logic [NSRC-1:0] pol_o,
  output logic            irq_o
);

  logic [NSRC-1:0] mask_q, mode_q, pol_q, latch_q;
  logic [NSRC-1:0] now_act, was_act, edge_hit, ack_bits, latch_d;
  logic            irq_q;

  // polarity-corrected view of the current and previous synchronized input
  assign now_act  = ~(sync_i ^ pol_q);
  assign was_act  = ~(prev_i ^ pol_q);
  assign edge_hit = now_act & ~was_act;

  assign ack_bits = (wr_i && wsel_i == REG_ACK) ? wdata_i : '0;
  // a new edge overrides an acknowledge in the same cycle
  assign latch_d  = mode_q & ((latch_q & ~ack_bits) | edge_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (wr_i) begin
        case (wsel_i)
          REG_MASK: mask_q <= wdata_i;
          REG_MODE: mode_q <= wdata_i;
          REG_POL:  pol_q  <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign pend_o  = (mode_q & latch_q) | (~mode_q & now_act);
  assign epend_o = pend_o & mask_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pol_o   = pol_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |epend_o;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_dual_ctrl.sv
module irq_dual_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_n_o,
  output logic            irq_f_o
);

  localparam int UPPER_W = AW - SPACE_BITS;

  logic [NSRC-1:0] src_sync, src_prev;
  logic            addr_hit, bank_sel;
  reg_sel_e        rsel;
  logic [NSRC-1:0] pend  [NBANKS];
  logic [NSRC-1:0] epend [NBANKS];
  logic [NSRC-1:0] mask  [NBANKS];
  logic [NSRC-1:0] mode  [NBANKS];
  logic [NSRC-1:0] pol   [NBANKS];
  logic            irq   [NBANKS];
  logic [NSRC-1:0] rd_sel_val;
  logic [DW-1:0]   rdata_q;

  irq_sync #(.W(NSRC), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (src_i),
    .sync_o (src_sync),
    .prev_o (src_prev)
  );

  assign rsel     = reg_sel_e'(bus_addr[4:2]);
  assign bank_sel = bus_addr[BANK_BIT];
  assign addr_hit = (bus_addr[AW-1:SPACE_BITS] == UPPER_W'(0)) &&
                    (bus_addr[1:0] == 2'b00) &&
                    (int'(bus_addr[4:2]) < NREGS);

  genvar b;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = bus_wr && addr_hit && (bank_sel == b[0]);
      irq_bank #(.NSRC(NSRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (src_sync),
        .prev_i  (src_prev),
        .wr_i    (bank_wr),
        .wsel_i  (rsel),
        .wdata_i (bus_wdata[NSRC-1:0]),
        .pend_o  (pend[b]),
        .epend_o (epend[b]),
        .mask_o  (mask[b]),
        .mode_o  (mode[b]),
        .pol_o   (pol[b]),
        .irq_o   (irq[b])
      );
    end
  endgenerate

  always_comb begin
    rd_sel_val = '0;
    if (addr_hit) begin
      case (rsel)
        REG_PEND:  rd_sel_val = pend[bank_sel];
        REG_MASK:  rd_sel_val = mask[bank_sel];
        REG_MODE:  rd_sel_val = mode[bank_sel];
        REG_POL:   rd_sel_val = pol[bank_sel];
        REG_EPEND: rd_sel_val = epend[bank_sel];
        default:   rd_sel_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= DW'(rd_sel_val);
  end

  assign bus_rdata = rdata_q;
  assign irq_n_o   = irq[0];
  assign irq_f_o   = irq[1];

endmodule

// File: rtl/irq_dual_ctrl_chk.sv
module irq_dual_ctrl_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          irq_n_o,
  input logic          irq_f_o
);

  logic unmapped, ack_addr;
  assign unmapped = (bus_addr[1:0] != 2'b00) || ((bus_addr >> 6) != '0) ||
                    (bus_addr[4:2] > 3'd5);
  assign ack_addr = (bus_addr[4:2] == 3'd2);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_n_o && !irq_f_o && bus_rdata == '0));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> bus_rdata == '0);

  assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ack_addr) |=> bus_rdata == '0);

  assert_mask_off_normal_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8'h04) && bus_wdata == '0) |=> ##1 !irq_n_o);

  assert_mask_off_fast_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(8'h24) && bus_wdata == '0) |=> ##1 !irq_f_o);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind irq_dual_ctrl irq_dual_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_n_o   (irq_n_o),
  .irq_f_o   (irq_f_o)
);

// File: tb/test_irq_dual_ctrl.sv
module test_irq_dual_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n, irq_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_dual_ctrl i_irq_dual_ctrl (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_n_o   (irq_n),
    .irq_f_o   (irq_f)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_in [3];
  logic [31:0] m_mask [2], m_mode [2], m_pol [2], m_lat [2];
  logic        m_irq [2];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    logic [31:0] act, act_old, edges, pend, en, clr, nxt_lat [2];
    logic        nxt_irq [2];
    logic [31:0] nxt_rd;
    int          bank, idx;
    bit          mapped;
    if (rst) begin
      for (int k = 0; k < 3; k++) m_in[k] = '0;
      for (int k = 0; k < 2; k++) begin
        m_mask[k] = '0; m_mode[k] = '0; m_pol[k] = '0; m_lat[k] = '0; m_irq[k] = 0;
      end
      m_rd = '0;
    end else begin
      bank   = bus_addr[5];
      idx    = bus_addr[4:2];
      mapped = (bus_addr[1:0] == 0) && (bus_addr < 8'h40) && (idx < 6);
      nxt_rd = m_rd;
      for (int k = 0; k < 2; k++) begin
        act     = ~(m_in[1] ^ m_pol[k]);
        act_old = ~(m_in[2] ^ m_pol[k]);
        edges   = act & ~act_old;
        pend    = (m_mode[k] & m_lat[k]) | (~m_mode[k] & act);
        en      = pend & m_mask[k];
        nxt_irq[k] = (en != 0);
        if (bus_rd && mapped && bank == k) begin
          case (idx)
            0: nxt_rd = pend;
            1: nxt_rd = m_mask[k];
            3: nxt_rd = m_mode[k];
            4: nxt_rd = m_pol[k];
            5: nxt_rd = en;
            default: nxt_rd = 0;
          endcase
        end
        clr = (bus_wr && mapped && bank == k && idx == 2) ? bus_wdata : 0;
        nxt_lat[k] = m_mode[k] & ((m_lat[k] & ~clr) | edges);
      end
      if (bus_rd && !mapped) nxt_rd = 0;
      for (int k = 0; k < 2; k++) begin
        m_lat[k] = nxt_lat[k];
        m_irq[k] = nxt_irq[k];
        if (bus_wr && mapped && bank == k) begin
          if (idx == 1) m_mask[k] = bus_wdata;
          if (idx == 3) m_mode[k] = bus_wdata;
          if (idx == 4) m_pol[k]  = bus_wdata;
        end
      end
      m_rd    = nxt_rd;
      m_in[2] = m_in[1];
      m_in[1] = m_in[0];
      m_in[0] = src;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R5 R6 R10 timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R10 model irq_n", {31'd0, irq_n}, {31'd0, m_irq[0]});
      check("R9 model irq_f",  {31'd0, irq_f}, {31'd0, m_irq[1]});
      check("R11 model rdata", bus_rdata, m_rd);
    end
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_n after reset", {31'd0, irq_n}, 32'd0);
    check("R1 irq_f after reset", {31'd0, irq_f}, 32'd0);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    idle(3);
    rd(8'h04, v); check("R1 mask reset", v, 32'd0);
    rd(8'h00, v); check("R4 low-active idle inputs pend", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R3 masked view zero", v, 32'd0);

    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    idle(1);
    rd(8'h00, v); check("R4 active-high idle pend", v, 32'd0);

    src = 32'h1;
    wr(8'h04, 32'h1);
    idle(4);
    check("R5 level irq_n", {31'd0, irq_n}, 32'd1);
    check("R9 fast stays off", {31'd0, irq_f}, 32'd0);
    rd(8'h14, v); check("R3 masked view", v, 32'h1);

    wr(8'h04, 32'h0);
    idle(3);
    check("R10 mask off drops irq_n", {31'd0, irq_n}, 32'd0);
    rd(8'h00, v); check("R3 pend unaffected by mask", v, 32'h1);
    rd(8'h14, v); check("R3 masked view off", v, 32'h0);

    wr(8'h08, 32'h1);
    idle(1);
    rd(8'h00, v); check("R7 ack ignored for level", v, 32'h1);

    wr(8'h10, 32'hFFFF_FFFD);
    idle(1);
    rd(8'h00, v); check("R4 active-low bit1", v, 32'h3);
    src = 32'h0;
    idle(4);
    rd(8'h00, v); check("R5 level follows input", v, 32'h2);

    wr(8'h0C, 32'h4);
    wr(8'h04, 32'h4);
    src = 32'h4; idle(4);
    src = 32'h0; idle(4);
    rd(8'h00, v); check("R6 rising edge latched", v, 32'h6);
    check("R6 edge irq_n", {31'd0, irq_n}, 32'd1);
    rd(8'h14, v); check("R6 masked edge", v, 32'h4);

    wr(8'h08, 32'h4);
    idle(3);
    rd(8'h00, v); check("R7 ack clears latch", v, 32'h2);
    check("R7 irq_n after ack", {31'd0, irq_n}, 32'd0);

    wr(8'h0C, 32'hC);
    wr(8'h10, 32'hFFFF_FFF5);
    idle(3);
    rd(8'h00, v); check("R4 polarity change no edge", v, 32'h2);
    src = 32'h8; idle(4);
    rd(8'h00, v); check("R4 rise ignored in falling mode", v, 32'h2);
    src = 32'h0; idle(4);
    rd(8'h00, v); check("R4 falling edge latched", v, 32'hA);

    wr(8'h08, 32'h0);
    idle(1);
    rd(8'h00, v); check("R7 zero bits no effect", v, 32'hA);

    wr(8'h0C, 32'h4);
    wr(8'h0C, 32'hC);
    idle(1);
    rd(8'h00, v); check("R12 level mode drops latch", v, 32'h2);

    src = 32'h4;
    @(negedge clk);
    @(negedge clk);
    wr(8'h08, 32'h4);
    idle(2);
    rd(8'h00, v); check("R8 edge wins over ack", v, 32'h6);
    wr(8'h08, 32'h4);
    src = 32'h0;
    idle(4);
    rd(8'h00, v); check("R7 ack after collision", v, 32'h2);

    wr(8'h24, 32'h1);
    src = 32'h1;
    idle(4);
    check("R9 fast irq on", {31'd0, irq_f}, 32'd1);
    check("R9 normal irq off", {31'd0, irq_n}, 32'd0);
    rd(8'h34, v); check("R9 fast masked view", v, 32'h1);
    rd(8'h20, v); check("R9 fast pend view", v, 32'h1);

    rd(8'h18, v); check("R2 index 6 reads zero", v, 32'h0);
    rd(8'h40, v); check("R2 high address reads zero", v, 32'h0);
    rd(8'h06, v); check("R2 misaligned reads zero", v, 32'h0);
    rd(8'h08, v); check("R2 ack reads zero", v, 32'h0);

    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    idle(1);
    rd(8'h04, v); check("R11 mask unchanged", v, 32'h4);
    rd(8'h00, v); check("R11 pend unchanged", v, 32'h3);
    rd(8'h0C, v); check("R11 mode readback", v, 32'hC);
    rd(8'h10, v); check("R11 polarity readback", v, 32'hFFFF_FFF5);
    rd(8'h24, v); check("R9 fast mask unchanged", v, 32'h1);
    idle(3);
    check("R11 rdata held", bus_rdata, 32'h1);

    finish_run();
  end

endmodule